// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block gathers up to 32 interrupt sources onto one request line toward a processor. Each source is first synchronised to the local clock. Its trigger type is then chosen from two per-source bits: a sensing bit (edge or level) and a sense-direction bit (high/rising or low/falling). Events latch into a pending vector. Software clears that vector by writing ones and gates it with a per-source unmask vector. Software can also inject an event on any source by writing a one into a write-only injection word.

The gated pending bits are ORed into one request. The request reaches the output pin in one of two ways: as a level, or as a single-cycle strobe each time the request becomes newly present. The strobe is used by parents that sense edges. Either form can be inverted, and the output polarity resets to active low. The register port is a plain word-addressed bus with address, write strobe, write data and combinational read data.

Top module: `trig_irq_ctrl`

## Requirements
- R1: After reset the unmask word, pending word, output-form bit and output-sense bit read zero. Every source's sensing bit reads 0 and its direction bit reads 1, so every source is level high. With these values the output pin is high (inactive, active low).
- R2: The word index is address bits [4:2]: 0 unmask, 1 pending, 2 sensing, 3 direction, 4 output form (bit 0), 5 output sense (bit 0), 6 injection. The unmask, sensing and direction words read back in full. The two output words read back bit 0 only. The injection word, indices 7 and up, and any address with bits [1:0] nonzero read as zero, and writes to them have no effect.
- R3: A source with sensing=1 and direction=1 latches its pending bit on a 0-to-1 input transition; with direction=0 it latches on 1-to-0. The opposite transition does not set it. The bit stays set after the input returns.
- R4: A source with sensing=0 sets its pending bit while the input equals the direction bit (high for 1, low for 0). A write-one to that bit is ignored while the level is still active. Once the level is inactive the bit stays set until a write-one clears it.
- R5: For an edge source, writing 1 to its pending bit clears it, and writing 0 leaves it set.
- R6: Writing 1 to an injection bit sets the matching pending bit at the same clock edge, whatever the input.
- R7: With output form 0 the pin equals the OR of (pending AND unmask) when output sense is 1, and its inverse when output sense is 0. A pending bit whose unmask bit is 0 has no effect on the pin.
- R8: With output form 1 the pin carries one active cycle when the gated request goes from absent to present. It stays inactive while the request persists, even if further sources fire. The active value is high for output sense 1 and low for output sense 0.
- R9: An input change is first seen in the pending word after the third rising clock edge following it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 32 | Asynchronous interrupt source inputs |
| irq_out | output | 1 | Combined interrupt request line |

## Verification
The assertions take for granted that source inputs are stable for at least two cycles around each intended transition, so that a change passes whole through the synchroniser. They also assume that each bus write lasts exactly one cycle, with address and data steady over the clock edge. The stimulus changes sources only one clock after an edge and holds each level for several cycles. It issues every write as a single-cycle strobe and returns the write strobe low before the next access. Trigger types are changed only while the affected input sits at its inactive level, followed by a write-one clear, so no mode change is counted as an event.

// File: rtl/irq_pkg.sv
// Shared definitions for the trigger interrupt controller.
// Assumes the register file is word addressed with byte addresses.
package irq_pkg;
    // Word index of each register; the software driver relies on these.
    typedef enum logic [2:0] {
        REG_UNMASK  = 3'd0,
        REG_PENDING = 3'd1,
        REG_SENSE   = 3'd2,
        REG_DIR     = 3'd3,
        REG_OFORM   = 3'd4,
        REG_OSENSE  = 3'd5,
        REG_INJECT  = 3'd6
    } reg_idx_e;
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each input bit is independent; no bus coherency is implied.
module irq_sync #(
    parameter int N_SRC  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] async_in,
    output logic [N_SRC-1:0] sync_out
);
    logic [STAGES-1:0][N_SRC-1:0] stg_q;

    // Shift the inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= {stg_q[STAGES-2:0], async_in};
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/irq_trig.sv
// Per-source trigger detection and pending-bit latching.
// Assumes inputs are already synchronised; injection and write-one clear
// arrive as one-cycle vectors from the register block.
module irq_trig #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] sync_in,
    input  logic [N_SRC-1:0] sense,
    input  logic [N_SRC-1:0] dir,
    input  logic [N_SRC-1:0] w1c,
    input  logic [N_SRC-1:0] inject,
    output logic [N_SRC-1:0] pending
);
    logic [N_SRC-1:0] prev_q;
    logic [N_SRC-1:0] pend_d;

    // Remember last synchronised input for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        logic act_now, act_prev, set_b, clr_b;
        // Active means the input matches the selected direction.
        assign act_now  = ~(sync_in[i] ^ dir[i]);
        assign act_prev = ~(prev_q[i] ^ dir[i]);
        // Edge sensing sets on entry to active; level sensing while active.
        assign set_b    = (sense[i] ? (act_now & ~act_prev) : act_now) | inject[i];
        // Level sources refuse a clear while still active.
        assign clr_b    = w1c[i] & (sense[i] | ~act_now);
        assign pend_d[i] = set_b | (pending[i] & ~clr_b);
    end

    // Latch the pending vector.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= '0;
        else        pending <= pend_d;
    end
endmodule

// File: rtl/irq_regs.sv
// Register file: unmask, trigger configuration, output configuration,
// write-one-clear and injection strobes, and combinational read mux.
// Assumes single-cycle writes; misaligned accesses are ignored.
module irq_regs
    import irq_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    input  logic [N_SRC-1:0]  pending,
    output logic [N_SRC-1:0]  bus_rdata,
    output logic [N_SRC-1:0]  unmask,
    output logic [N_SRC-1:0]  sense,
    output logic [N_SRC-1:0]  dir,
    output logic              oform,
    output logic              osense,
    output logic [N_SRC-1:0]  w1c,
    output logic [N_SRC-1:0]  inject
);
    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] widx;
    logic             wr_ok;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign widx    = bus_addr[ADDR_W-1:2];
    assign wr_ok   = bus_we & aligned;

    // Strobes into the trigger block, active only during the write cycle.
    assign w1c    = (wr_ok && widx == IDX_W'(REG_PENDING)) ? bus_wdata : '0;
    assign inject = (wr_ok && widx == IDX_W'(REG_INJECT))  ? bus_wdata : '0;

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unmask <= '0;
            sense  <= '0;
            dir    <= '1;
            oform  <= 1'b0;
            osense <= 1'b0;
        end else if (wr_ok) begin
            if (widx == IDX_W'(REG_UNMASK)) unmask <= bus_wdata;
            if (widx == IDX_W'(REG_SENSE))  sense  <= bus_wdata;
            if (widx == IDX_W'(REG_DIR))    dir    <= bus_wdata;
            if (widx == IDX_W'(REG_OFORM))  oform  <= bus_wdata[0];
            if (widx == IDX_W'(REG_OSENSE)) osense <= bus_wdata[0];
        end
    end

    // Select read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (widx == IDX_W'(REG_UNMASK))  bus_rdata = unmask;
            if (widx == IDX_W'(REG_PENDING)) bus_rdata = pending;
            if (widx == IDX_W'(REG_SENSE))   bus_rdata = sense;
            if (widx == IDX_W'(REG_DIR))     bus_rdata = dir;
            if (widx == IDX_W'(REG_OFORM))   bus_rdata = {{(N_SRC-1){1'b0}}, oform};
            if (widx == IDX_W'(REG_OSENSE))  bus_rdata = {{(N_SRC-1){1'b0}}, osense};
        end
    end
endmodule

// File: rtl/irq_outgen.sv
// Output stage: gates pending with unmask, forms level or strobe output
// and applies output polarity.
// Assumes pending and unmask are registered upstream.
module irq_outgen #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pending,
    input  logic [N_SRC-1:0] unmask,
    input  logic             oform,
    input  logic             osense,
    output logic             irq_out
);
    logic req, req_q, strobe, active;

    assign req = |(pending & unmask);

    // Track the request for new-request detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    assign strobe  = req & ~req_q;
    assign active  = oform ? strobe : req;
    assign irq_out = osense ? active : ~active;
endmodule

// File: rtl/trig_irq_ctrl.sv
// Top level of the trigger interrupt controller: synchroniser, trigger
// detection, register file and output stage.
// Assumes src_in is asynchronous and the bus is synchronous to clk.
module trig_irq_ctrl #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 5,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [N_SRC-1:0]  bus_wdata,
    output logic [N_SRC-1:0]  bus_rdata,
    input  logic [N_SRC-1:0]  src_in,
    output logic              irq_out
);
    logic [N_SRC-1:0] sync_q, status_q, en_q, mode_q, pol_q, w1c_v, inj_v;
    logic             omode_q, opol_q;

    irq_sync #(.N_SRC(N_SRC), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(src_in), .sync_out(sync_q)
    );

    irq_trig #(.N_SRC(N_SRC)) u_trig (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_q), .sense(mode_q),
        .dir(pol_q), .w1c(w1c_v), .inject(inj_v), .pending(status_q)
    );

    irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .pending(status_q), .bus_rdata(bus_rdata),
        .unmask(en_q), .sense(mode_q), .dir(pol_q), .oform(omode_q),
        .osense(opol_q), .w1c(w1c_v), .inject(inj_v)
    );

    irq_outgen #(.N_SRC(N_SRC)) u_out (
        .clk(clk), .rst_n(rst_n), .pending(status_q), .unmask(en_q),
        .oform(omode_q), .osense(opol_q), .irq_out(irq_out)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
// Assertion checker for trig_irq_ctrl, attached by bind.
// Assumes the bus write strobe lasts a single cycle per access.
module irq_ctrl_chk #(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [N_SRC-1:0]  bus_wdata,
    input logic [N_SRC-1:0]  bus_rdata,
    input logic [N_SRC-1:0]  sync_q,
    input logic [N_SRC-1:0]  status_q,
    input logic [N_SRC-1:0]  en_q,
    input logic [N_SRC-1:0]  mode_q,
    input logic [N_SRC-1:0]  pol_q,
    input logic              omode_q,
    input logic              opol_q,
    input logic              irq_out
);
    logic [N_SRC-1:0] sync_d, lvl_act, edge_evt;

    // Checker's own copy of the previous synchronised input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_d <= '0;
        else        sync_d <= sync_q;
    end

    assign lvl_act  = ~mode_q & ~(sync_q ^ pol_q);
    assign edge_evt = mode_q & ~(sync_q ^ pol_q) & (sync_d ^ pol_q);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status_q == '0 && en_q == '0 && !omode_q && !opol_q));

    // R2
    inject_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(5'h18)) |-> (bus_rdata == '0));

    // R3
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_evt != '0) |=> ((status_q & $past(edge_evt)) == $past(edge_evt)));

    // R4
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_act != '0) |=> ((status_q & $past(lvl_act)) == $past(lvl_act)));

    // R6
    inject_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(5'h18))
        |=> ((status_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R7
    level_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !omode_q |-> (irq_out == (opol_q ? |(status_q & en_q) : ~|(status_q & en_q))));

    // R8
    strobe_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (omode_q && opol_q && irq_out) |=> !(omode_q && opol_q && irq_out));
endmodule

bind trig_irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_q(sync_q),
    .status_q(status_q), .en_q(en_q), .mode_q(mode_q), .pol_q(pol_q),
    .omode_q(omode_q), .opol_q(opol_q), .irq_out(irq_out)
);

// File: tb/tb_trig_irq_ctrl.sv
// Self-checking bench for trig_irq_ctrl: register sweep, trigger-type
// sweep over several sources, injection and both output forms.
module tb_trig_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] A_EN = 5'h00, A_ST = 5'h04, A_MD = 5'h08,
                           A_PL = 5'h0C, A_OM = 5'h10, A_OP = 5'h14, A_FC = 5'h18;

    always #2.5 clk = ~clk;

    trig_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .irq_out(irq_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic pin(input logic exp, input string tag);
        chk(irq_out === exp, tag, {31'b0, irq_out}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int srcs[3] = '{0, 7, 31};
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        rd(A_EN, 32'h0, "R1 unmask");
        rd(A_ST, 32'h0, "R1 pending");
        rd(A_OM, 32'h0, "R1 oform");
        rd(A_OP, 32'h0, "R1 osense");
        rd(A_MD, 32'h0, "R1 sense");
        rd(A_PL, 32'hFFFF_FFFF, "R1 dir");
        pin(1'b1, "R1 pin idle");

        // R2 register readback
        wr(A_EN, 32'hA5A5_5A5A); rd(A_EN, 32'hA5A5_5A5A, "R2 unmask");
        wr(A_MD, 32'h1234_8765); rd(A_MD, 32'h1234_8765, "R2 sense");
        wr(A_PL, 32'hF0F0_0F0F); rd(A_PL, 32'hF0F0_0F0F, "R2 dir");
        wr(A_OM, 32'hFFFF_FFFE); rd(A_OM, 32'h0, "R2 oform bit0");
        wr(A_OP, 32'hFFFF_FFFF); rd(A_OP, 32'h1, "R2 osense bit0");
        rd(A_FC, 32'h0, "R2 inject reads zero");
        rd(5'h1C, 32'h0, "R2 unmapped");
        wr(5'h01, 32'h0); rd(5'h01, 32'h0, "R2 misaligned read");
        rd(A_EN, 32'hA5A5_5A5A, "R2 misaligned write ignored");
        wr(A_EN, 32'h0); wr(A_OP, 32'h0);
        wr(A_MD, 32'h0); wr(A_PL, 32'hFFFF_FFFF);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, 32'h0, "R2 restored pending");

        // R3 R4 R5 R9 trigger-type sweep
        foreach (srcs[k]) begin
            for (int ty = 0; ty < 4; ty++) begin
                automatic int s = srcs[k];
                automatic bit md = ty[1];
                automatic bit pl = ty[0];
                automatic logic [31:0] b = 32'h1 << s;
                src_in[s] = ~pl; cyc(4);
                wr(A_MD, md ? b : 32'h0);
                wr(A_PL, ~32'h0 & (pl ? ~32'h0 : ~b));
                wr(A_ST, b);
                rd(A_ST, 32'h0, $sformatf("R2 clear before src%0d type%0d", s, ty));
                src_in[s] = pl;
                cyc(2); rd(A_ST, 32'h0, $sformatf("R9 not yet src%0d type%0d", s, ty));
                cyc(1); rd(A_ST, b, $sformatf("R9 seen src%0d type%0d", s, ty));
                if (md) begin
                    wr(A_ST, ~b); rd(A_ST, b, $sformatf("R5 zero keeps src%0d", s));
                    wr(A_ST, b);  rd(A_ST, 32'h0, $sformatf("R5 one clears src%0d", s));
                    src_in[s] = ~pl; cyc(4);
                    rd(A_ST, 32'h0, $sformatf("R3 opposite edge src%0d pol%0d", s, pl));
                end else begin
                    wr(A_ST, b); rd(A_ST, b, $sformatf("R4 clear ignored active src%0d", s));
                    src_in[s] = ~pl; cyc(4);
                    rd(A_ST, b, $sformatf("R4 sticky src%0d pol%0d", s, pl));
                    wr(A_ST, b); rd(A_ST, 32'h0, $sformatf("R4 cleared src%0d", s));
                end
                src_in[s] = 1'b0; cyc(4);
                wr(A_MD, 32'h0); wr(A_PL, 32'hFFFF_FFFF); wr(A_ST, 32'hFFFF_FFFF);
            end
        end

        // R6 injection
        wr(A_FC, 32'h0000_0020);
        rd(A_ST, 32'h0000_0020, "R6 inject sets");
        cyc(3); rd(A_ST, 32'h0000_0020, "R6 inject holds");
        wr(A_ST, 32'hFFFF_FFFF);

        // R7 level output
        wr(A_FC, 32'h8);
        pin(1'b1, "R7 masked active-low idle");
        wr(A_EN, 32'h8);  pin(1'b0, "R7 unmasked active-low");
        wr(A_OP, 32'h1);  pin(1'b1, "R7 active-high");
        wr(A_EN, 32'h10); pin(1'b0, "R7 other unmask only");
        wr(A_ST, 32'hFFFF_FFFF); wr(A_EN, 32'hFFFF_FFFF);
        pin(1'b0, "R7 nothing pending");

        // R8 strobe output
        wr(A_OM, 32'h1);
        pin(1'b0, "R8 idle");
        wr(A_FC, 32'h200); pin(1'b1, "R8 strobe");
        cyc(1);            pin(1'b0, "R8 strobe one cycle");
        wr(A_FC, 32'h400); pin(1'b0, "R8 no strobe while present");
        wr(A_ST, 32'hFFFF_FFFF); cyc(1);
        wr(A_OP, 32'h0);   pin(1'b1, "R8 low-sense idle");
        wr(A_FC, 32'h1);   pin(1'b0, "R8 low-sense strobe");
        cyc(1);            pin(1'b1, "R8 low-sense end");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule